// File: doc/BRIEF.md
# Oscillator Time Base and Clock Supervisor

This block turns a nominal 16 kHz oscillator into the 1 ms logic tick that the rest of the supervision logic counts with. It also checks, from a separate and independent reference clock, that the oscillator is still toggling. The tick is a one-cycle strobe in the oscillator domain, produced by a divide-by-`DIV` prescaler. It is not a derived clock, so downstream logic uses it as an enable.

The supervisor brings the oscillator level into the reference domain through a two-flop synchroniser. It times each high phase and each low phase with a counter that restarts on every synchronised edge. If one phase lasts `STUCK_CYC` reference cycles, the clock is declared dead and the error flag is set. With the default values (a 16 kHz reference) this is about 120 ms. The flag holds until power-on reset, and downstream logic uses it to force the safe output state.

Top module: `oscsup_top`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `tick_o` and `clk_err_o` are both 0.
- R2: After reset release, `tick_o` is high in the oscillator cycle that follows the `DIV`-th rising edge of `osc_clk`. It is high again every `DIV` rising edges after that.
- R3: `tick_o` is high for exactly one `osc_clk` cycle per tick. It is low in the cycle after each tick.
- R4: While `osc_clk` keeps toggling with each phase shorter than `STUCK_CYC` reference cycles (fast or near the limit), `clk_err_o` stays 0.
- R5: If `osc_clk` stays high for more than `STUCK_CYC` plus 4 `ref_clk` cycles, `clk_err_o` goes to 1. It does not go to 1 earlier than about `STUCK_CYC` minus 10 cycles after the last edge.
- R6: If `osc_clk` stays low for more than `STUCK_CYC` plus 4 `ref_clk` cycles, `clk_err_o` goes to 1, with the same window as R5.
- R7: Once set, `clk_err_o` stays 1 even when the oscillator resumes toggling. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Monitored oscillator, nominally 16 kHz |
| ref_clk | input | 1 | Independent free-running reference clock for the supervisor |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_o | output | 1 | One-cycle tick strobe in the `osc_clk` domain |
| clk_err_o | output | 1 | Latched clock-dead flag in the `ref_clk` domain |

## Verification
The bound checker checks the following on every cycle:
- the exact spacing of the tick strobe and its one-cycle width, using its own cycle counter;
- that the error flag never drops once it is set;
- that the flag rises only after the synchronised oscillator level has stayed quiet for the full window.

Other behaviours only the directed scenarios can show:
- that a healthy clock, including one whose phases come close to the limit, never raises the flag;
- that stuck-high and stuck-low both raise it within the expected window;
- that restarting the oscillator leaves the flag set until reset.

// File: rtl/oscsup_pkg.sv
package oscsup_pkg;
  // Default divide ratio: 16 kHz oscillator down to a 1 kHz tick.
  localparam int DEF_DIV       = 16;
  // Default stuck window: about 120 ms of a 16 kHz reference.
  localparam int DEF_STUCK_CYC = 1920;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } osc_phase_e;
endpackage

// File: rtl/oscsup_prescaler.sv
module oscsup_prescaler #(
  parameter int DIV = oscsup_pkg::DEF_DIV
) (
  input  logic osc_clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      tick_q <= (cnt_q == LAST);
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/oscsup_sync.sv
module oscsup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          chain_q[s] <= 1'b0;
        else if (s == 0)
          chain_q[s] <= d_i;
        else
          chain_q[s] <= chain_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/oscsup_stuck_timer.sv
module oscsup_stuck_timer #(
  parameter int STUCK_CYC = oscsup_pkg::DEF_STUCK_CYC
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic err_o
);
  import oscsup_pkg::*;

  localparam int CW = $clog2(STUCK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STUCK_CYC);

  osc_phase_e    phase_q;
  logic [CW-1:0] len_q;
  logic          err_q;
  logic          edge_w;

  assign edge_w = (osc_phase_e'(lvl_i) != phase_q);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LOW;
      len_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      phase_q <= osc_phase_e'(lvl_i);
      if (edge_w)
        len_q <= '0;
      else if (len_q != LIMIT)
        len_q <= len_q + 1'b1;
      if (len_q == LIMIT)
        err_q <= 1'b1;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/oscsup_top.sv
module oscsup_top #(
  parameter int DIV       = oscsup_pkg::DEF_DIV,
  parameter int STUCK_CYC = oscsup_pkg::DEF_STUCK_CYC
) (
  input  logic osc_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic tick_o,
  output logic clk_err_o
);
  logic sync_lvl;

  oscsup_prescaler #(.DIV(DIV)) u_presc (
    .osc_clk (osc_clk),
    .rst_n   (rst_n),
    .tick_o  (tick_o)
  );

  oscsup_sync #(.STAGES(2)) u_sync (
    .clk   (ref_clk),
    .rst_n (rst_n),
    .d_i   (osc_clk),
    .q_o   (sync_lvl)
  );

  oscsup_stuck_timer #(.STUCK_CYC(STUCK_CYC)) u_timer (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .lvl_i   (sync_lvl),
    .err_o   (clk_err_o)
  );
endmodule

// File: rtl/oscsup_checker.sv
module oscsup_checker #(
  parameter int DIV       = 16,
  parameter int STUCK_CYC = 1920
) (
  input logic osc_clk,
  input logic ref_clk,
  input logic rst_n,
  input logic tick_o,
  input logic clk_err_o,
  input logic lvl
);
  localparam int SW = $clog2(DIV + 1) + 1;
  localparam int QW = $clog2(STUCK_CYC + 1);

  logic [SW-1:0] since_q;
  logic [QW-1:0] quiet_q;
  logic          lvl_prev_q;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= '0;
    else if (tick_o)
      since_q <= SW'(1);
    else if (since_q <= SW'(DIV))
      since_q <= since_q + 1'b1;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev_q <= 1'b0;
      quiet_q    <= '0;
    end else begin
      lvl_prev_q <= lvl;
      if (lvl != lvl_prev_q)
        quiet_q <= '0;
      else if (quiet_q != QW'(STUCK_CYC))
        quiet_q <= quiet_q + 1'b1;
    end
  end

  // R2: a tick appears exactly DIV oscillator cycles apart
  p_tick_period_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    tick_o == (since_q == SW'(DIV)));

  // R3: the strobe is one cycle wide
  p_tick_single_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  // R5 / R6: the flag rises only after a full quiet window
  p_err_after_quiet_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(clk_err_o) |-> ($past(quiet_q) >= QW'(STUCK_CYC)));

  // R7: the flag is sticky
  p_err_sticky_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_err_o |=> clk_err_o);
endmodule

bind oscsup_top oscsup_checker #(.DIV(DIV), .STUCK_CYC(STUCK_CYC)) i_chk (
  .osc_clk   (osc_clk),
  .ref_clk   (ref_clk),
  .rst_n     (rst_n),
  .tick_o    (tick_o),
  .clk_err_o (clk_err_o),
  .lvl       (sync_lvl)
);

// File: tb/test_oscsup_top.sv
`timescale 1ns/1ps
module test_oscsup_top;
  localparam int DIV       = 16;
  localparam int STUCK_CYC = 200;

  logic ref_clk = 1'b0;
  logic osc_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic tick_o;
  logic clk_err_o;

  bit osc_run  = 1'b1;
  bit hold_lvl = 1'b0;
  int half_ns  = 83;

  int n_checks = 0;
  int n_fail   = 0;

  oscsup_top #(.DIV(DIV), .STUCK_CYC(STUCK_CYC)) i_oscsup_top (
    .osc_clk   (osc_clk),
    .ref_clk   (ref_clk),
    .rst_n     (rst_n),
    .tick_o    (tick_o),
    .clk_err_o (clk_err_o)
  );

  always #5 ref_clk = ~ref_clk;

  always begin
    #(half_ns);
    if (osc_run) osc_clk = ~osc_clk;
    else         osc_clk = hold_lvl;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ref_wait(input int n);
    for (int k = 0; k < n; k++) @(negedge ref_clk);
  endtask

  // R1: outputs cleared in reset and right after release (release mid low phase)
  task automatic t_reset;
    rst_n   = 1'b0;
    osc_run = 1'b1;
    half_ns = 83;
    ref_wait(20);
    check(tick_o == 1'b0, "R1 tick in reset", tick_o, 0);
    check(clk_err_o == 1'b0, "R1 err in reset", clk_err_o, 0);
    @(negedge osc_clk);
    #5 rst_n = 1'b1;
    @(negedge ref_clk);
    check(tick_o == 1'b0, "R1 tick after release", tick_o, 0);
    check(clk_err_o == 1'b0, "R1 err after release", clk_err_o, 0);
  endtask

  // R2 / R3: tick after every DIV-th rising edge, one cycle wide
  task automatic t_tick;
    int seen = 0;
    for (int i = 1; i <= 4 * DIV; i++) begin
      @(posedge osc_clk);
      @(negedge osc_clk);
      if (i % DIV == 0) begin
        check(tick_o == 1'b1, "R2 tick expected", tick_o, 1);
        seen++;
      end else if (i % DIV == 1 && i > 1)
        check(tick_o == 1'b0, "R3 tick width", tick_o, 0);
      else
        check(tick_o == 1'b0, "R2 tick off", tick_o, 0);
    end
    check(seen == 4, "R2 tick count", seen, 4);
  endtask

  // R4: no error while toggling, fast or close to the window
  task automatic t_toggle(input int h, input int cycles);
    half_ns = h;
    osc_run = 1'b1;
    ref_wait(cycles);
    check(clk_err_o == 1'b0, "R4 healthy clock", clk_err_o, 0);
  endtask

  // R5 / R6: stuck phase raises the flag within the window
  task automatic t_stuck(input bit lvl, input string tag);
    half_ns  = 83;
    hold_lvl = lvl;
    osc_run  = 1'b0;
    ref_wait(3 + STUCK_CYC - 30);
    check(clk_err_o == 1'b0, {tag, " too early"}, clk_err_o, 0);
    ref_wait(50);
    check(clk_err_o == 1'b1, {tag, " flag set"}, clk_err_o, 1);
  endtask

  // R7: flag stays set after the oscillator restarts, reset clears it
  task automatic t_sticky;
    osc_run = 1'b1;
    half_ns = 83;
    ref_wait(400);
    check(clk_err_o == 1'b1, "R7 sticky after restart", clk_err_o, 1);
    rst_n = 1'b0;
    ref_wait(3);
    check(clk_err_o == 1'b0, "R7 cleared by reset", clk_err_o, 0);
  endtask

  initial begin
    t_reset();
    t_tick();
    t_toggle(83, 2000);
    t_toggle(1500, 3000);
    t_stuck(1'b1, "R5");
    t_sticky();
    t_reset();
    t_toggle(83, 500);
    t_stuck(1'b0, "R6");
    t_sticky();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule